// File: doc/BRIEF.md
# Rectifier Zero-Current Cutoff Gate

This block sits between the PWM sequencer and the low-side gate driver of a synchronous buck controller. Each switching cycle, it decides whether the synchronous rectifier may stay on for the whole off-time or must be shut early. Shutting it early stops the inductor current from reversing. A comparator reports when the switch node has climbed above a small negative threshold, which means the inductor current has reached zero. That report only counts after the rectifier has been on for a blanking interval, because switching noise right after turn-on can trip the comparator falsely.

Once a cutoff has been taken, the block holds the rectifier off until the next cycle-start strobe, even if the request drops and comes back. A two-bit mode picks how the cutoff applies. In source-only operation it is always armed. In pre-bias-safe operation it is armed only while soft start is running, so the converter never sinks current from an output that was already charged. In source/sink operation it is never armed. A fault input forces the rectifier enable high, so the low-side switch clamps the output during a fault.

Top module: `zc_rect_gate`

## Requirements
- R1: With the cutoff armed, if `zcFlag` is sampled high on a clock edge where `rectReq` is high and blanking is over, `rectEn` goes low from the following cycle.
- R2: After a cutoff, `rectEn` stays low while `rectReq` is held high or toggled. This lasts until an edge that samples `cycleStart` high. From the next cycle on, `rectEn` follows `rectReq` again.
- R3: Blanking covers the first `BLANK_CYCLES` clock edges that sample `rectReq` high after it was sampled low. On those edges `zcFlag` is ignored. Default is 4 edges.
- R4: Mode encoding: 0 arms the cutoff at all times. 1 arms it only while `softStartActive` is high. 2 never arms it. 3 behaves like 0.
- R5: While `faultForce` is high, `rectEn` is high in the same cycle, whatever the other inputs are.
- R6: With `faultForce` low, `rectEn` is low in any cycle where `rectReq` is low.
- R7: During reset the cutoff latch is clear, so `rectEn` equals `rectReq` OR `faultForce`.
- R8: If `cycleStart` and a valid zero-current indication are sampled on the same edge, the cycle start wins and no cutoff is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rectReq | input | 1 | Rectifier on-request from the PWM sequencer |
| zcFlag | input | 1 | Zero-current comparator output (switch node above threshold) |
| softStartActive | input | 1 | High while the soft-start ramp is running |
| mode | input | 2 | Cutoff mode (see R4) |
| faultForce | input | 1 | Fault override that forces the rectifier on |
| cycleStart | input | 1 | Strobe marking the start of a PWM cycle |
| rectEn | output | 1 | Gated rectifier enable to the low-side driver |

## Verification
`rectEn` is a combinational function of `rectReq`, `faultForce` and one registered cutoff latch. Changes to the request or the fault show up in the same cycle. A zero-current indication, or a cycle start, takes effect one edge after it is sampled. Blanking counts the edges that sample the request high. The bench drives every input just after the falling edge. It checks `rectEn` one time unit later, then advances a reference model at the rising edge. Each compare therefore sees the latch state produced by all earlier edges and none of the current one.

// File: rtl/zc_gate_pkg.sv
package zc_gate_pkg;

  typedef enum logic [1:0] {
    MODE_SRC_ONLY = 2'd0,
    MODE_PREBIAS  = 2'd1,
    MODE_SRC_SINK = 2'd2,
    MODE_SPARE    = 2'd3
  } cutMode_e;

  // strobes from control to the blanking datapath
  typedef struct packed {
    logic blankLoad;
    logic blankStep;
  } blankStrobe_t;

endpackage

// File: rtl/zc_blank_timer.sv
module zc_blank_timer
  import zc_gate_pkg::*;
#(
  parameter int BLANK_CYCLES = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  blankStrobe_t strobe,
  output logic         blankDone
);

  localparam int CW = (BLANK_CYCLES > 1) ? $clog2(BLANK_CYCLES) : 1;
  localparam logic [CW-1:0] LOAD_VAL = CW'(BLANK_CYCLES - 1);

  logic [CW-1:0] blankCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blankCnt <= '0;
    end else if (strobe.blankLoad) begin
      blankCnt <= LOAD_VAL;
    end else if (strobe.blankStep && (blankCnt != '0)) begin
      blankCnt <= blankCnt - CW'(1);
    end
  end

  assign blankDone = (blankCnt == '0);

  // R3: a load starts a full blanking window
  a_r3_blank_load: assert property (@(posedge clk) disable iff (!rstN)
    strobe.blankLoad |=> (blankCnt == LOAD_VAL));

  // R3: the count only moves downward while stepping
  a_r3_blank_down: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.blankLoad && !blankDone) |=> (blankCnt <= $past(blankCnt)));

endmodule

// File: rtl/zc_cut_ctrl.sv
module zc_cut_ctrl
  import zc_gate_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         rectReq,
  input  logic         zcFlag,
  input  logic         softStartActive,
  input  logic [1:0]   mode,
  input  logic         cycleStart,
  input  logic         blankDone,
  output blankStrobe_t strobe,
  output logic         cutLatched
);

  logic reqQ;
  logic riseNow;
  logic senseOpen;
  logic cutArmed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reqQ <= 1'b0;
    else       reqQ <= rectReq;
  end

  assign riseNow          = rectReq & ~reqQ;
  assign strobe.blankLoad = riseNow;
  assign strobe.blankStep = rectReq & ~riseNow & ~blankDone;
  assign senseOpen        = rectReq & reqQ & blankDone;

  always_comb begin
    unique case (cutMode_e'(mode))
      MODE_SRC_ONLY: cutArmed = 1'b1;
      MODE_PREBIAS:  cutArmed = softStartActive;
      MODE_SRC_SINK: cutArmed = 1'b0;
      MODE_SPARE:    cutArmed = 1'b1;
      default:       cutArmed = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               cutLatched <= 1'b0;
    else if (cycleStart)                     cutLatched <= 1'b0;
    else if (senseOpen && zcFlag && cutArmed) cutLatched <= 1'b1;
  end

  // R2: once taken, the cutoff holds until a cycle start
  a_r2_cut_hold: assert property (@(posedge clk) disable iff (!rstN)
    (cutLatched && !cycleStart) |=> cutLatched);

  // R8: a sampled cycle start always leaves the latch clear
  a_r8_start_clears: assert property (@(posedge clk) disable iff (!rstN)
    cycleStart |=> !cutLatched);

  // R3: no cutoff while the blanking window is open
  a_r3_no_cut_blanked: assert property (@(posedge clk) disable iff (!rstN)
    (!cutLatched && !blankDone) |=> !cutLatched);

  // R4: source/sink mode never takes a cutoff
  a_r4_srcsink_free: assert property (@(posedge clk) disable iff (!rstN)
    (!cutLatched && mode == 2'd2) |=> !cutLatched);

  // R1: a cutoff only follows a zero-current indication
  a_r1_cut_cause: assert property (@(posedge clk) disable iff (!rstN)
    (!cutLatched && !zcFlag) |=> !cutLatched);

endmodule

// File: rtl/zc_rect_gate.sv
module zc_rect_gate
  import zc_gate_pkg::*;
#(
  parameter int BLANK_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rectReq,
  input  logic       zcFlag,
  input  logic       softStartActive,
  input  logic [1:0] mode,
  input  logic       faultForce,
  input  logic       cycleStart,
  output logic       rectEn
);

  blankStrobe_t strobe;
  logic         blankDone;
  logic         cutLatched;

  zc_cut_ctrl u_ctrl (
    .clk             (clk),
    .rstN            (rstN),
    .rectReq         (rectReq),
    .zcFlag          (zcFlag),
    .softStartActive (softStartActive),
    .mode            (mode),
    .cycleStart      (cycleStart),
    .blankDone       (blankDone),
    .strobe          (strobe),
    .cutLatched      (cutLatched)
  );

  zc_blank_timer #(.BLANK_CYCLES(BLANK_CYCLES)) u_blank (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .blankDone (blankDone)
  );

  assign rectEn = faultForce | (rectReq & ~cutLatched);

  // R5: fault override
  a_r5_fault_on: assert property (@(posedge clk) disable iff (!rstN)
    faultForce |-> rectEn);

  // R6: no request, no enable
  a_r6_req_low: assert property (@(posedge clk) disable iff (!rstN)
    (!rectReq && !faultForce) |-> !rectEn);

endmodule

// File: tb/zc_rect_gate_test.sv
module zc_rect_gate_test;
  localparam int CLK_PERIOD = 10;
  localparam int BLANK = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rectReq = 1'b0, zcFlag = 1'b0, softStartActive = 1'b0;
  logic [1:0] mode = 2'd0;
  logic faultForce = 1'b0, cycleStart = 1'b0;
  logic rectEn;

  int checks = 0;
  int errors = 0;

  bit mReqQ = 0;
  int mCnt = 0;
  bit mCut = 0;

  zc_rect_gate #(.BLANK_CYCLES(BLANK)) uut (
    .clk(clk), .rstN(rstN), .rectReq(rectReq), .zcFlag(zcFlag),
    .softStartActive(softStartActive), .mode(mode), .faultForce(faultForce),
    .cycleStart(cycleStart), .rectEn(rectEn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic bit cutOn(input logic [1:0] md, input bit ss);
    case (md)
      2'd1:    return ss;
      2'd2:    return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  task automatic check(input logic act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: rectEn actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit req, input bit zc, input bit ss, input logic [1:0] md,
                      input bit flt, input bit cs, input string tagIn);
    string tag;
    @(negedge clk);
    rectReq = req; zcFlag = zc; softStartActive = ss; mode = md;
    faultForce = flt; cycleStart = cs;
    #1;
    tag = tagIn;
    if (tag == "") tag = flt ? "R5" : (!req ? "R6" : (mCut ? "R2" : "R1"));
    check(rectEn, flt | (req & ~mCut), tag);
    @(posedge clk);
    if (cs) mCut = 0;
    else if (req && mReqQ && mCnt == 0 && zc && cutOn(md, ss)) mCut = 1;
    if (req && !mReqQ) mCnt = BLANK - 1;
    else if (req && mCnt != 0) mCnt--;
    mReqQ = req;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R7: reset state
    rectReq = 1'b1; #1; check(rectEn, 1'b1, "R7");
    rectReq = 1'b0; faultForce = 1'b1; #1; check(rectEn, 1'b1, "R7");
    faultForce = 1'b0; #1; check(rectEn, 1'b0, "R7");
    repeat (2) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R3 then R1: zc held high through blanking, cut right after it
    step(0, 0, 0, 2'd0, 0, 1, "R6");
    for (int i = 0; i < BLANK; i++) step(1, 1, 0, 2'd0, 0, 0, "R3");
    step(1, 1, 0, 2'd0, 0, 0, "R1");
    step(1, 0, 0, 2'd0, 0, 0, "R1");
    // R2: hold off across request toggle
    step(0, 0, 0, 2'd0, 0, 0, "R2");
    step(1, 0, 0, 2'd0, 0, 0, "R2");
    step(1, 0, 0, 2'd0, 0, 1, "R2");
    step(1, 0, 0, 2'd0, 0, 0, "R2");
    // R5: fault while cut
    for (int i = 0; i < BLANK + 1; i++) step(1, 1, 0, 2'd0, 0, 0, "R1");
    step(1, 0, 0, 2'd0, 1, 0, "R5");
    step(0, 0, 0, 2'd0, 1, 1, "R5");
    // R4: each mode after blanking
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 2; s++) begin
        step(0, 0, s[0], 2'(m), 0, 1, "R4");
        for (int i = 0; i < BLANK + 3; i++) step(1, 1, s[0], 2'(m), 0, 0, "R4");
      end
    end
    // R8: cycle start beats simultaneous zc
    step(0, 0, 0, 2'd0, 0, 1, "R8");
    for (int i = 0; i < BLANK; i++) step(1, 0, 0, 2'd0, 0, 0, "R8");
    step(1, 1, 0, 2'd0, 0, 1, "R8");
    step(1, 0, 0, 2'd0, 0, 0, "R8");
    // random mix
    for (int n = 0; n < 4000; n++) begin
      step(($urandom % 8) != 0, ($urandom % 3) == 0, $urandom % 2, 2'($urandom % 4),
           ($urandom % 16) == 0, ($urandom % 10) == 0, "");
    end
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule